// File: doc/BRIEF.md
# Pipelined Synchronous Word Memory with Byte-Lane Writes

This block is a single-clock static memory, 32 bits wide, made of four 8-bit lanes and a parameterised number of words. An access starts with an active-low address strobe. On that rising edge the block samples the address, the write data, the write controls and three chip enables. If the chip is selected, the access is registered. On the following edge the write goes into the array, or the addressed word moves into an output register. No other timing from outside is needed.

There are two levels of write qualification. A global write stores the whole word. Without it, four per-lane strobes pick the bytes to store, but only while a byte-write enable is asserted. A selected access that stores no lane is a read. Several devices can share a bus by using the three chip enables. Burst address sequencing is done by a separate generator.

Top module: `pipe_sram`

## Requirements
- R1: While `rstN` is low and on the first edge after it, `rdData` is zero.
- R2: A selected access with `gwN` low writes all four lanes with `wrData`, whatever `bweN` and `byteStbN` are.
- R3: With `gwN` high and `bweN` low, each low bit `byteStbN[i]` writes bits 8i+7:8i. So bit 0 controls 7:0, bit 1 controls 15:8, bit 2 controls 23:16 and bit 3 controls 31:24.
- R4: During a write, a lane whose strobe is high keeps its previous contents.
- R5: With `gwN` high and `bweN` high, the byte strobes have no effect. The access is a read and changes no memory contents.
- R6: An access is accepted only when `ce1N` is low, `ce2` is high and `ce3N` is low at the strobe edge. A deselected strobe neither writes nor changes `rdData`.
- R7: Read data appears on `rdData` after the second rising edge following the read strobe. It then holds until the next read.
- R8: Cycles with `addrStbN` high ignore every other input. Memory contents and `rdData` are unchanged.
- R9: A read strobed in the cycle right after a write to the same address returns the newly written word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset of control and output register |
| addrStbN | input | 1 | Active-low address strobe, starts an access |
| ce1N | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ce3N | input | 1 | Chip enable, active low |
| addr | input | $clog2(DEPTH) | Word address |
| wrData | input | 32 | Write data |
| gwN | input | 1 | Active-low global write, all lanes |
| bweN | input | 1 | Active-low byte-write enable |
| byteStbN | input | 4 | Active-low per-lane write strobes |
| rdData | output | 32 | Registered read data |

## Verification
A write to the array and the capture of the next access can fall on the same edge. This happens when a write is strobed and a read of the same address is strobed in the very next cycle. The bench provokes this case and expects the read to return the word just stored, merged with the untouched lanes. The expected word comes from a model memory that applies the lane rules independently.

// File: rtl/pipe_sram_pkg.sv
package pipe_sram_pkg;
  localparam int LANES  = 4;
  localparam int LANE_W = 8;
  localparam int DATA_W = LANES * LANE_W;

  typedef struct packed {
    logic             capture;
    logic             wrEn;
    logic             rdEn;
    logic [LANES-1:0] laneEn;
  } opStrobes_t;
endpackage

// File: rtl/pipe_sram_ctrl.sv
module pipe_sram_ctrl
  import pipe_sram_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             addrStbN,
  input  logic             ce1N,
  input  logic             ce2,
  input  logic             ce3N,
  input  logic             gwN,
  input  logic             bweN,
  input  logic [LANES-1:0] byteStbN,
  output opStrobes_t       ops
);
  logic             selected;
  logic             accept;
  logic [LANES-1:0] laneMask;
  logic             wrQ;
  logic             rdQ;
  logic [LANES-1:0] laneQ;

  assign selected = !ce1N && ce2 && !ce3N;
  assign accept   = !addrStbN && selected;

  always_comb begin
    if (!gwN)       laneMask = '1;
    else if (!bweN) laneMask = ~byteStbN;
    else            laneMask = '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrQ   <= 1'b0;
      rdQ   <= 1'b0;
      laneQ <= '0;
    end else begin
      wrQ   <= accept && (|laneMask);
      rdQ   <= accept && !(|laneMask);
      laneQ <= accept ? laneMask : '0;
    end
  end

  always_comb begin
    ops.capture = accept;
    ops.wrEn    = wrQ;
    ops.rdEn    = rdQ;
    ops.laneEn  = laneQ;
  end
endmodule

// File: rtl/pipe_sram_data.sv
module pipe_sram_data
  import pipe_sram_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  opStrobes_t        ops,
  input  logic [AW-1:0]     addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);
  logic [AW-1:0]                addrQ;
  logic [LANES-1:0][LANE_W-1:0] dataQ;
  logic [LANES-1:0][LANE_W-1:0] rdWord;

  always_ff @(posedge clk) begin
    if (ops.capture) begin
      addrQ <= addr;
      dataQ <= wrData;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic [LANE_W-1:0] laneMem [DEPTH];
    logic [LANE_W-1:0] laneOut;

    always_ff @(posedge clk) begin
      if (ops.wrEn && ops.laneEn[g]) laneMem[addrQ] <= dataQ[g];
    end

    always_ff @(posedge clk) begin
      if (!rstN)          laneOut <= '0;
      else if (ops.rdEn)  laneOut <= laneMem[addrQ];
    end

    assign rdWord[g] = laneOut;
  end

  assign rdData = rdWord;
endmodule

// File: rtl/pipe_sram.sv
module pipe_sram
  import pipe_sram_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              addrStbN,
  input  logic              ce1N,
  input  logic              ce2,
  input  logic              ce3N,
  input  logic [AW-1:0]     addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              gwN,
  input  logic              bweN,
  input  logic [LANES-1:0]  byteStbN,
  output logic [DATA_W-1:0] rdData
);
  opStrobes_t ops;

  pipe_sram_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .addrStbN (addrStbN),
    .ce1N     (ce1N),
    .ce2      (ce2),
    .ce3N     (ce3N),
    .gwN      (gwN),
    .bweN     (bweN),
    .byteStbN (byteStbN),
    .ops      (ops)
  );

  pipe_sram_data #(.DEPTH(DEPTH)) i_data (
    .clk    (clk),
    .rstN   (rstN),
    .ops    (ops),
    .addr   (addr),
    .wrData (wrData),
    .rdData (rdData)
  );
endmodule

// File: rtl/pipe_sram_chk.sv
module pipe_sram_chk
  import pipe_sram_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              addrStbN,
  input logic              ce1N,
  input logic              ce2,
  input logic              ce3N,
  input logic              gwN,
  input logic              bweN,
  input opStrobes_t        ops,
  input logic [DATA_W-1:0] rdData
);
  logic chipOn;
  assign chipOn = !ce1N && ce2 && !ce3N;

  a_r1_reset_clear: assert property (@(posedge clk) !rstN |=> rdData == '0);

  a_r2_global_all: assert property (@(posedge clk) disable iff (!rstN)
    (!addrStbN && chipOn && !gwN) |=> (ops.wrEn && ops.laneEn == '1 && !ops.rdEn));

  a_r5_bwe_off_read: assert property (@(posedge clk) disable iff (!rstN)
    (!addrStbN && chipOn && gwN && bweN) |=> (!ops.wrEn && ops.rdEn));

  a_r6_deselect_idle: assert property (@(posedge clk) disable iff (!rstN)
    (!addrStbN && !chipOn) |=> (!ops.wrEn && !ops.rdEn));

  a_r7_hold_output: assert property (@(posedge clk) disable iff (!rstN)
    !ops.rdEn |=> $stable(rdData));

  a_r8_no_strobe_idle: assert property (@(posedge clk) disable iff (!rstN)
    addrStbN |=> (!ops.wrEn && !ops.rdEn));

  a_r4_single_op: assert property (@(posedge clk) disable iff (!rstN)
    !(ops.wrEn && ops.rdEn));
endmodule

bind pipe_sram pipe_sram_chk i_chk (
  .clk      (clk),
  .rstN     (rstN),
  .addrStbN (addrStbN),
  .ce1N     (ce1N),
  .ce2      (ce2),
  .ce3N     (ce3N),
  .gwN      (gwN),
  .bweN     (bweN),
  .ops      (ops),
  .rdData   (rdData)
);

// File: tb/test_pipe_sram.sv
module test_pipe_sram;
  localparam int DEPTH = 64;
  localparam int AW    = $clog2(DEPTH);

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          addrStbN = 1'b1;
  logic          ce1N = 1'b0, ce2 = 1'b1, ce3N = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0]   wrData = '0;
  logic          gwN = 1'b1, bweN = 1'b1;
  logic [3:0]    byteStbN = 4'hF;
  logic [31:0]   rdData;

  logic [31:0] model [DEPTH];
  int testsRun = 0;
  int testsFailed = 0;

  always #10 clk = ~clk;

  pipe_sram #(.DEPTH(DEPTH)) i_pipe_sram (
    .clk(clk), .rstN(rstN), .addrStbN(addrStbN),
    .ce1N(ce1N), .ce2(ce2), .ce3N(ce3N),
    .addr(addr), .wrData(wrData), .gwN(gwN), .bweN(bweN),
    .byteStbN(byteStbN), .rdData(rdData)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic goIdle();
    addrStbN = 1'b1; ce1N = 1'b0; ce2 = 1'b1; ce3N = 1'b0;
    gwN = 1'b1; bweN = 1'b1; byteStbN = 4'hF;
  endtask

  // Drive one access at a negedge; return after its capture edge, inputs idle.
  task automatic access(input logic [AW-1:0] a, input logic [31:0] d, input logic g,
                        input logic b, input logic [3:0] s, input logic c1,
                        input logic c2, input logic c3);
    addrStbN = 1'b0; addr = a; wrData = d; gwN = g; bweN = b; byteStbN = s;
    ce1N = c1; ce2 = c2; ce3N = c3;
    @(negedge clk);
    goIdle();
  endtask

  task automatic modelWrite(input logic [AW-1:0] a, input logic [31:0] d, input logic [3:0] m);
    for (int i = 0; i < 4; i++) if (m[i]) model[a][8*i +: 8] = d[8*i +: 8];
  endtask

  task automatic writeWord(input logic [AW-1:0] a, input logic [31:0] d,
                           input logic g, input logic b, input logic [3:0] s);
    logic [3:0] m;
    m = !g ? 4'hF : (!b ? ~s : 4'h0);
    access(a, d, g, b, s, 1'b0, 1'b1, 1'b0);
    @(negedge clk);
    modelWrite(a, d, m);
  endtask

  task automatic readWord(input logic [AW-1:0] a, output logic [31:0] q);
    access(a, 32'hDEAD_BEEF, 1'b1, 1'b1, 4'hF, 1'b0, 1'b1, 1'b0);
    @(negedge clk);
    q = rdData;
  endtask

  task automatic tReset();
    check("R1 reset output", rdData, 32'h0);
  endtask

  task automatic tGlobalWrite();
    logic [31:0] q;
    writeWord(6'd1, 32'h1122_3344, 1'b0, 1'b1, 4'hF);
    readWord(6'd1, q);
    check("R2 global write, bwe off", q, 32'h1122_3344);
    writeWord(6'd1, 32'hA5A5_5A5A, 1'b0, 1'b0, 4'b1110);
    readWord(6'd1, q);
    check("R2 global write overrides strobes", q, 32'hA5A5_5A5A);
  endtask

  task automatic tByteLanes();
    logic [31:0] q;
    writeWord(6'd2, 32'h0000_0000, 1'b0, 1'b1, 4'hF);
    for (int i = 0; i < 4; i++) begin
      logic [3:0] s;
      s = ~(4'b0001 << i);
      writeWord(6'd2, {4{8'h10 + 8'(i)}}, 1'b1, 1'b0, s);
      readWord(6'd2, q);
      check($sformatf("R3 lane %0d write", i), q, model[2]);
    end
    writeWord(6'd3, 32'hFFFF_FFFF, 1'b0, 1'b1, 4'hF);
    writeWord(6'd3, 32'h1234_5678, 1'b1, 1'b0, 4'b1010);
    readWord(6'd3, q);
    check("R4 unselected lanes kept", q, 32'hFF34_FF78);
  endtask

  task automatic tBweOff();
    logic [31:0] q;
    writeWord(6'd4, 32'hCAFE_F00D, 1'b0, 1'b1, 4'hF);
    access(6'd4, 32'h0, 1'b1, 1'b1, 4'h0, 1'b0, 1'b1, 1'b0);
    @(negedge clk);
    check("R5 strobes ignored, read result", rdData, 32'hCAFE_F00D);
    readWord(6'd4, q);
    check("R5 memory unchanged", q, 32'hCAFE_F00D);
  endtask

  task automatic tDeselect();
    logic [31:0] q;
    writeWord(6'd5, 32'h5555_0005, 1'b0, 1'b1, 4'hF);
    writeWord(6'd6, 32'h6666_0006, 1'b0, 1'b1, 4'hF);
    for (int k = 0; k < 3; k++) begin
      logic c1, c2, c3;
      c1 = (k == 0); c2 = (k != 1); c3 = (k == 2);
      readWord(6'd5, q);
      access(6'd6, 32'h0, 1'b1, 1'b1, 4'hF, c1, c2, c3);
      @(negedge clk);
      check($sformatf("R6 deselect %0d read ignored", k), rdData, 32'h5555_0005);
      access(6'd5, 32'hBAD0_0000, 1'b0, 1'b1, 4'hF, c1, c2, c3);
      @(negedge clk);
      readWord(6'd5, q);
      check($sformatf("R6 deselect %0d write ignored", k), q, 32'h5555_0005);
    end
  endtask

  task automatic tNoStrobe();
    logic [31:0] q;
    readWord(6'd6, q);
    addrStbN = 1'b1; addr = 6'd6; wrData = 32'h0BAD_0BAD; gwN = 1'b0; bweN = 1'b0; byteStbN = 4'h0;
    repeat (3) @(negedge clk);
    check("R8 no strobe output stable", rdData, 32'h6666_0006);
    goIdle();
    readWord(6'd6, q);
    check("R8 no strobe memory unchanged", q, 32'h6666_0006);
  endtask

  task automatic tLatency();
    logic [31:0] q;
    writeWord(6'd7, 32'h7777_7777, 1'b0, 1'b1, 4'hF);
    readWord(6'd6, q);
    access(6'd7, 32'h0, 1'b1, 1'b1, 4'hF, 1'b0, 1'b1, 1'b0);
    check("R7 not yet after capture edge", rdData, 32'h6666_0006);
    @(negedge clk);
    check("R7 visible after second edge", rdData, 32'h7777_7777);
    repeat (2) @(negedge clk);
    check("R7 held without read", rdData, 32'h7777_7777);
  endtask

  task automatic tBackToBack();
    writeWord(6'd8, 32'h0000_0000, 1'b0, 1'b1, 4'hF);
    addrStbN = 1'b0; addr = 6'd8; wrData = 32'hABCD_EF01; gwN = 1'b1; bweN = 1'b0; byteStbN = 4'b0110;
    @(negedge clk);
    modelWrite(6'd8, 32'hABCD_EF01, 4'b1001);
    gwN = 1'b1; bweN = 1'b1; byteStbN = 4'hF; wrData = 32'h0;
    @(negedge clk);
    goIdle();
    @(negedge clk);
    check("R9 read right after write", rdData, model[8]);
    check("R9 merged value", rdData, 32'hAB00_0001);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    testsFailed++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    goIdle();
    repeat (3) @(negedge clk);
    tReset();
    rstN = 1'b1;
    @(negedge clk);
    check("R1 first edge after reset", rdData, 32'h0);
    tGlobalWrite();
    tByteLanes();
    tBweOff();
    tDeselect();
    tNoStrobe();
    tLatency();
    tBackToBack();
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule